// File: doc/BRIEF.md
# Configurable Command/Address Registered Buffer with Parity Check

This block is the clocked register on the command and address path of a registered memory module. On every rising clock edge it captures an input word and drives it out from flip-flops. A two-bit configuration input chooses the topology. In the straight topology every input bit has its own output. In the fan-out topology a 14-bit slice of the inputs is copied onto two output lanes. In that case the configuration also marks the part as the lower (A) or upper (B) register of a pair, and this choice decides which slice is used.

The block checks an incoming parity bit against the data bits that are active in the chosen topology. The convention is even parity. The result is registered one cycle behind the data, and an error is reported on an active-low error output that is either pulled low or released. Two active-low chip-selects gate the data lanes: when neither rank is selected, the data outputs keep their last value. The registered chip-selects, clock-enable and on-die-termination outputs always follow their inputs.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rstN` is low, `qA`, `qB`, `csNOut`, `ckeOut` and `odtOut` are 0, `qerrN` is 1 and `qerrDrive` is 0.
- R2: With `cfgIn[0]`=0 (straight topology), a selected edge makes `qA` equal the sampled `dIn`, and `qB` stays 0.
- R3: With `cfgIn`=2'b01 (fan-out, register A), a selected edge makes both `qB` and `qA[13:0]` equal `dIn[13:0]` in the same cycle, and `qA[24:14]` is 0.
- R4: With `cfgIn`=2'b11 (fan-out, register B), a selected edge makes both `qB` and `qA[13:0]` equal `dIn[24:11]`, and `qA[24:14]` is 0.
- R5: An edge at which `csNIn`=2'b11 (no rank selected) leaves `qA` and `qB` unchanged.
- R6: `csNOut`, `ckeOut` and `odtOut` take the values of `csNIn`, `ckeIn` and `odtIn` at every edge, whether or not a rank is selected.
- R7: At a selected edge k, the checked bits are all of `dIn` in the straight topology and the 14 used bits in the fan-out topology. If these bits together with `parIn` hold an odd number of ones, then after edge k+1 `qerrN` is 0 and `qerrDrive` is 1. If the count is even, `qerrN` is 1 and `qerrDrive` is 0.
- R8: In the fan-out topology, the input bits outside the used slice change neither the data outputs nor the parity result.
- R9: An edge with `csNIn`=2'b11 never produces a parity error, whatever the data and parity.
- R10: The configuration is sampled at the first edge after reset. Later changes of `cfgIn` have no effect until the next reset.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgIn | input | 2 | Bit 0: fan-out topology; bit 1: register B (fan-out only) |
| dIn | input | 25 | Command/address data inputs |
| parIn | input | 1 | Even-parity bit from the controller |
| csNIn | input | 2 | Rank chip-selects, active low |
| ckeIn | input | 1 | Clock-enable input |
| odtIn | input | 1 | Termination-control input |
| qA | output | 25 | Primary registered data lane |
| qB | output | 14 | Second copy lane in fan-out topology, 0 otherwise |
| csNOut | output | 2 | Registered chip-selects |
| ckeOut | output | 1 | Registered clock-enable |
| odtOut | output | 1 | Registered termination control |
| qerrN | output | 1 | Parity error level, low on error |
| qerrDrive | output | 1 | Enable of the error pull-down |

## Verification
Several properties are checked on every clock cycle. The lanes hold whenever no rank is selected. The copy lanes match in the fan-out topology, and the copy lane stays 0 in the straight one. The always-updating sideband outputs follow their inputs. An unselected edge never raises an error, an error is only flagged two edges after a checked capture, and the latched topology stays fixed between resets. The bench scenarios are the only place to show the right slice for register A versus register B, the exact even-parity result over each set of checked bits, and that unused bits have no effect. They also show that a change of configuration after reset is ignored.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadData;  // at least one rank selected: data lanes capture
    logic checkEn;   // parity result of this edge counts
    logic dualMode;  // fan-out topology
    logic selB;      // upper slice feeds the lanes (register B)
  } strobe_t;
endpackage

// File: rtl/cmd_regbuf_ctrl.sv
module cmd_regbuf_ctrl
  import cmd_regbuf_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      cfgIn,
  input  logic [CS_W-1:0] csNIn,
  output strobe_t         strb
);
  logic       cfgLocked;
  logic [1:0] cfgHeld;
  logic [1:0] cfgEff;

  // Topology is frozen at the first edge after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLocked <= 1'b0;
      cfgHeld   <= '0;
    end else if (!cfgLocked) begin
      cfgLocked <= 1'b1;
      cfgHeld   <= cfgIn;
    end
  end

  assign cfgEff = cfgLocked ? cfgHeld : cfgIn;

  always_comb begin
    strb.dualMode = cfgEff[0];
    strb.selB     = cfgEff[0] & cfgEff[1];
    strb.loadData = ~(&csNIn);
    strb.checkEn  = ~(&csNIn);
  end
endmodule

// File: rtl/cmd_regbuf_dp.sv
module cmd_regbuf_dp
  import cmd_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [WIDE_W-1:0]   dIn,
  input  logic                parIn,
  input  logic [CS_W-1:0]     csNIn,
  input  logic                ckeIn,
  input  logic                odtIn,
  output logic [WIDE_W-1:0]   qA,
  output logic [NARROW_W-1:0] qB,
  output logic [CS_W-1:0]     csNOut,
  output logic                ckeOut,
  output logic                odtOut,
  output logic                errFlag
);
  localparam int PAD_W = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] selWord;
  logic [WIDE_W-1:0]   nextA;
  logic [NARROW_W-1:0] nextB;
  logic                parOdd;
  logic                errNow;
  logic                errStage;

  always_comb begin
    selWord = strb.selB ? dIn[WIDE_W-1 -: NARROW_W] : dIn[NARROW_W-1:0];
    if (strb.dualMode) begin
      nextA  = {{PAD_W{1'b0}}, selWord};
      nextB  = selWord;
      parOdd = (^selWord) ^ parIn;
    end else begin
      nextA  = dIn;
      nextB  = '0;
      parOdd = (^dIn) ^ parIn;
    end
    errNow = parOdd & strb.checkEn;
  end

  // Chip-select gated data lanes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qA <= '0;
      qB <= '0;
    end else if (strb.loadData) begin
      qA <= nextA;
      qB <= nextB;
    end
  end

  // Sideband outputs and the two-stage parity pipeline.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csNOut   <= '0;
      ckeOut   <= 1'b0;
      odtOut   <= 1'b0;
      errStage <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      csNOut   <= csNIn;
      ckeOut   <= ckeIn;
      odtOut   <= odtIn;
      errStage <= errNow;
      errFlag  <= errStage;
    end
  end
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgIn,
  input  logic [WIDE_W-1:0]   dIn,
  input  logic                parIn,
  input  logic [CS_W-1:0]     csNIn,
  input  logic                ckeIn,
  input  logic                odtIn,
  output logic [WIDE_W-1:0]   qA,
  output logic [NARROW_W-1:0] qB,
  output logic [CS_W-1:0]     csNOut,
  output logic                ckeOut,
  output logic                odtOut,
  output logic                qerrN,
  output logic                qerrDrive
);
  strobe_t strb;
  logic    errFlag;

  cmd_regbuf_ctrl #(.CS_W(CS_W)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .cfgIn(cfgIn),
    .csNIn(csNIn),
    .strb (strb)
  );

  cmd_regbuf_dp #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CS_W(CS_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dIn    (dIn),
    .parIn  (parIn),
    .csNIn  (csNIn),
    .ckeIn  (ckeIn),
    .odtIn  (odtIn),
    .qA     (qA),
    .qB     (qB),
    .csNOut (csNOut),
    .ckeOut (ckeOut),
    .odtOut (odtOut),
    .errFlag(errFlag)
  );

  // Open-drain style error: pulled low while flagged, released otherwise.
  assign qerrN     = ~errFlag;
  assign qerrDrive = errFlag;
endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk
  import cmd_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [CS_W-1:0]     csNIn,
  input logic                ckeIn,
  input logic                odtIn,
  input logic [WIDE_W-1:0]   qA,
  input logic [NARROW_W-1:0] qB,
  input logic [CS_W-1:0]     csNOut,
  input logic                ckeOut,
  input logic                odtOut,
  input logic                qerrN,
  input logic                qerrDrive,
  input strobe_t             strb
);
  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (qA == '0 && qB == '0 && csNOut == '0 && !ckeOut
                                && !odtOut && qerrN && !qerrDrive);
    end
  end

  a_r2_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData && !strb.dualMode) |=> (qB == '0));

  a_r3_dup_pairs: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData && strb.dualMode) |=>
      (qA[NARROW_W-1:0] == qB && qA[WIDE_W-1:NARROW_W] == '0));

  a_r5_hold_unselected: assert property (@(posedge clk) disable iff (!rstN)
    (&csNIn) |=> ($stable(qA) && $stable(qB)));

  a_r6_sideband_follow: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (csNOut == $past(csNIn) && ckeOut == $past(ckeIn) && odtOut == $past(odtIn)));

  a_r7_err_after_check: assert property (@(posedge clk) disable iff (!rstN)
    qerrDrive |-> $past(strb.checkEn, 2));

  a_r9_unsel_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (&csNIn) |=> ##1 !qerrDrive);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable({strb.dualMode, strb.selB}));
endmodule

bind cmd_regbuf cmd_regbuf_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CS_W(CS_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csNIn    (csNIn),
  .ckeIn    (ckeIn),
  .odtIn    (odtIn),
  .qA       (qA),
  .qB       (qB),
  .csNOut   (csNOut),
  .ckeOut   (ckeOut),
  .odtOut   (odtOut),
  .qerrN    (qerrN),
  .qerrDrive(qerrDrive),
  .strb     (strb)
);

// File: tb/test_cmd_regbuf.sv
module test_cmd_regbuf;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [1:0]  cfgIn = 2'b00;
  logic [24:0] dIn = '0;
  logic        parIn = 1'b0;
  logic [1:0]  csNIn = 2'b11;
  logic        ckeIn = 1'b0;
  logic        odtIn = 1'b0;
  logic [24:0] qA;
  logic [13:0] qB;
  logic [1:0]  csNOut;
  logic        ckeOut;
  logic        odtOut;
  logic        qerrN;
  logic        qerrDrive;

  int total = 0;
  int failed = 0;

  // Stimulus table for the straight topology: {csN, badParity, data}
  localparam logic [27:0] VEC [8] = '{
    {2'b10, 1'b0, 25'h1ABCDEF},
    {2'b01, 1'b1, 25'h0F0F0F0},
    {2'b11, 1'b0, 25'h1555555},
    {2'b11, 1'b1, 25'h0000001},
    {2'b00, 1'b0, 25'h1FFFFFF},
    {2'b00, 1'b1, 25'h0000000},
    {2'b10, 1'b0, 25'h0123456},
    {2'b01, 1'b1, 25'h1000000}
  };

  logic [24:0] expQ;
  logic [24:0] vd;
  logic [1:0]  vcs;
  logic        vbad;
  logic        vsel;
  logic [13:0] sl;

  always #2 clk = ~clk;

  cmd_regbuf i_cmd_regbuf (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .dIn(dIn), .parIn(parIn),
    .csNIn(csNIn), .ckeIn(ckeIn), .odtIn(odtIn), .qA(qA), .qB(qB),
    .csNOut(csNOut), .ckeOut(ckeOut), .odtOut(odtOut),
    .qerrN(qerrN), .qerrDrive(qerrDrive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] cfg);
    rstN  = 1'b0;
    cfgIn = cfg;
    dIn   = 25'h1FFFFFF;
    parIn = 1'b1;
    csNIn = 2'b00;
    ckeIn = 1'b1;
    odtIn = 1'b1;
    step();
    step();
    chk("R1 qA", 32'(qA), 32'h0);
    chk("R1 qB", 32'(qB), 32'h0);
    chk("R1 sideband", {29'h0, csNOut, ckeOut}, 32'h0);
    chk("R1 odt", 32'(odtOut), 32'h0);
    chk("R1 qerrN", 32'(qerrN), 32'h1);
    chk("R1 qerrDrive", 32'(qerrDrive), 32'h0);
    rstN = 1'b1;
  endtask

  // Drive one fan-out vector, check lanes after one edge and error after two.
  task automatic dualVec(input string tag, input logic [24:0] d, input logic [13:0] used,
                         input logic bad);
    dIn   = d;
    parIn = (^used) ^ bad;
    csNIn = 2'b10;
    step();
    chk({tag, " qA"}, 32'(qA), {18'h0, used});
    chk({tag, " qB"}, 32'(qB), {18'h0, used});
    step();
    chk("R7 qerrN dual", 32'(qerrN), 32'(!bad));
    chk("R7 qerrDrive dual", 32'(qerrDrive), 32'(bad));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #1;
    // Straight topology: table walk (R2, R5, R6, R7, R9)
    doReset(2'b00);
    expQ = '0;
    for (int i = 0; i < 8; i++) begin
      vcs  = VEC[i][27:26];
      vbad = VEC[i][25];
      vd   = VEC[i][24:0];
      vsel = ~&vcs;
      dIn   = vd;
      parIn = (^vd) ^ vbad;
      csNIn = vcs;
      ckeIn = i[0];
      odtIn = i[1];
      step();
      if (vsel) expQ = vd;
      chk("R2/R5 qA", 32'(qA), 32'(expQ));
      chk("R2 qB zero", 32'(qB), 32'h0);
      chk("R6 csNOut", 32'(csNOut), 32'(vcs));
      chk("R6 cke/odt", {30'h0, odtOut, ckeOut}, {30'h0, i[1], i[0]});
      step();
      chk("R7/R9 qerrN", 32'(qerrN), 32'(!(vbad && vsel)));
      chk("R7/R9 qerrDrive", 32'(qerrDrive), 32'(vbad && vsel));
    end

    // Fan-out, register A (R3, R7, R8, R10)
    doReset(2'b01);
    vd = 25'h1ABCDEF;
    dualVec("R3", vd, vd[13:0], 1'b0);
    vd = vd ^ 25'h1FFC000;   // flip unused upper bits only, parity unchanged
    dualVec("R8 A", vd, vd[13:0], 1'b0);
    vd = 25'h0000007;
    dualVec("R7 A bad", vd, vd[13:0], 1'b1);
    cfgIn = 2'b00;           // late change must be ignored
    vd = 25'h1FFFFFF;
    dualVec("R10", vd, 14'h3FFF, 1'b0);

    // Fan-out, register B (R4, R7, R8)
    doReset(2'b11);
    vd = 25'h1ABCDEF;
    sl = vd[24:11];
    dualVec("R4", vd, sl, 1'b0);
    vd = vd ^ 25'h00007FF;   // flip unused low bits, odd count
    dualVec("R8 B", vd, sl, 1'b0);
    vd = 25'h0F0F0F0;
    sl = vd[24:11];
    dualVec("R7 B bad", vd, sl, 1'b1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule